// File: doc/BRIEF.md
# Stereo Audio Serializer with Selectable Framing

This block turns stereo 16-bit sample words into one serial audio data line. Each word carries both channels: bits [15:0] hold the left sample and bits [31:16] hold the right sample. A separate clock generator supplies two one-cycle enables in the system clock domain. One enable marks every bit-clock period. The other marks the bit period that opens a 64-bit frame. The block reads one word per frame from a show-ahead FIFO, and it places the bits according to the selected framing.

There are two framing families. The I2S family gives each channel its own 32-bit slot and aligns the 16 data bits within that slot. The alignment is standard (one bit of delay), left-justified or right-justified. The PCM family packs the two samples back to back, and a programmable delay of 0 to 3 bit clocks separates the frame start from the first data bit. Two format codes are checked: the sample-width code and the channel-count code. Only the 16-bit, two-channel setting transmits.

Top module: `audio_ser_tx`

## Requirements
- R1: A bit tick is a cycle with `bclk_en`=1. A tick that also has `frame_en`=1 is bit position 0 of a frame. Every later tick increments the position, and position 63 wraps to 0. Positions 0..31 form the left slot and positions 32..63 form the right slot.
- R2: With `pcm_frame`=0 and `align_mode`=0 (standard), the left sample `fifo_data[15:0]` is sent MSB first at slot positions 1..16. The right sample `fifo_data[31:16]` is sent the same way at positions 33..48. Every other position sends 0.
- R3: With `pcm_frame`=0 and `align_mode`=1 (left-justified), each sample's MSB is at slot position 0. Its 16 bits fill slot positions 0..15, and the rest of the slot is 0.
- R4: With `pcm_frame`=0 and `align_mode`=2 (right-justified), each sample fills slot positions 16..31, so its LSB is at the last position of the slot. `align_mode`=3 behaves like standard.
- R5: With `pcm_frame`=1, the left sample and then the right sample are sent MSB first as 32 consecutive bits. They start at frame position `pcm_delay` (0..3), and `align_mode` is ignored. All other positions send 0.
- R6: `sdo` takes the value for a tick's position on the clock edge that ends the tick cycle. It holds that value until the next tick's edge.
- R7: After reset `sdo`, `fifo_pop` and `underrun` are 0. Transmission begins at the first frame-start tick seen while `run`=1. Before that tick `sdo` is 0. While `run`=0, `sdo` is 0 from the next cycle on.
- R8: `fifo_pop` pulses for exactly the frame-start tick cycle of an active frame when `fifo_empty`=0. The word on `fifo_data` in that cycle is the word sent in that frame.
- R9: If `fifo_empty`=1 at the frame-start tick of an active frame, there is no pop, the whole frame is sent as zeros, and `underrun` becomes 1 from the next cycle. `underrun` stays 1 until `run` is 0. Whenever `run` is 0, `underrun` is cleared on the next edge.
- R10: Transmission requires `width_code`=4'hF (16-bit) and `chan_code`=2'd0 (two channels). Any other code makes the block behave as if `run`=0: `sdo` is 0 and there are no pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle pulse per bit-clock period |
| frame_en | input | 1 | Together with bclk_en, marks frame position 0 |
| run | input | 1 | Transmit start bit |
| pcm_frame | input | 1 | 0: I2S-family framing, 1: PCM framing |
| align_mode | input | 2 | I2S-family alignment: 0 standard, 1 left, 2 right |
| pcm_delay | input | 2 | PCM data delay after frame start, in bit clocks |
| width_code | input | 4 | Sample width code, 4'hF = 16 bit |
| chan_code | input | 2 | Channel count code, 0 = two channels |
| fifo_data | input | 32 | FIFO head word: right in [31:16], left in [15:0] |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Consumes the FIFO head word |
| sdo | output | 1 | Serial data output |
| underrun | output | 1 | Sticky flag: a frame started with no data |

## Verification
A wrong position count or a wrong active flag shows up on `sdo` at the next bit tick. It can also appear one frame later as a missing or extra `fifo_pop`, with no delay beyond a single frame. A held word that is corrupted or loaded at the wrong time changes `sdo` at the first data position of the affected slot. A wrong underrun state shows on `underrun` one cycle after the frame-start tick or after `run` falls. The reference model rebuilds each 64-bit frame from the FIFO head word and compares `sdo`, `fifo_pop` and `underrun` in every cycle, so any such fault is caught within one frame.

// File: rtl/audio_ser_tx_pkg.sv
package audio_ser_tx_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int WORD_W     = 2 * SAMPLE_W;
    localparam int SLOT_BITS  = 32;
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int IDX_W      = $clog2(SAMPLE_W);

    localparam logic [3:0] WIDTH_CODE_16 = 4'hF;
    localparam logic [1:0] CHAN_CODE_2   = 2'd0;

    typedef enum logic [1:0] {
        ALIGN_STD   = 2'd0,
        ALIGN_LEFT  = 2'd1,
        ALIGN_RIGHT = 2'd2,
        ALIGN_RSV   = 2'd3
    } align_e;

    typedef struct packed {
        logic       pcm;
        align_e     align;
        logic [1:0] delay;
    } frame_cfg_t;

    // Bit sent at frame position p for word w under configuration c.
    function automatic logic pick_bit(input logic [POS_W-1:0] p,
                                      input logic [WORD_W-1:0] w,
                                      input frame_cfg_t c);
        logic [SAMPLE_W-1:0] smp;
        logic [4:0]          k;
        logic [4:0]          std_idx;
        logic [POS_W-1:0]    q;
        logic [POS_W-1:0]    dl;
        logic                b;
        b   = 1'b0;
        k   = p[4:0];
        smp = p[5] ? w[WORD_W-1:SAMPLE_W] : w[SAMPLE_W-1:0];
        dl  = POS_W'(c.delay);
        q   = p - dl;
        std_idx = 5'd16 - k;
        if (c.pcm) begin
            if (p >= dl && !q[5]) begin
                smp = q[4] ? w[WORD_W-1:SAMPLE_W] : w[SAMPLE_W-1:0];
                b   = smp[4'd15 - q[3:0]];
            end
        end else begin
            case (c.align)
                ALIGN_LEFT:  if (!k[4]) b = smp[4'd15 - k[3:0]];
                ALIGN_RIGHT: if (k[4])  b = smp[4'd15 - k[3:0]];
                default:     if (k >= 5'd1 && k <= 5'd16) b = smp[std_idx[3:0]];
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/audio_ser_tx_bitpos.sv
module audio_ser_tx_bitpos
    import audio_ser_tx_pkg::*;
#(
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk_en,
    input  logic          frame_en,
    input  logic          go,
    output logic [PW-1:0] cur_pos,
    output logic          frame_start,
    output logic          active_now
);
    logic [PW-1:0] pos_q;
    logic          active_q;

    assign cur_pos     = frame_en ? '0 : pos_q + 1'b1;
    assign frame_start = bclk_en && frame_en;
    assign active_now  = go && (active_q || frame_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            active_q <= 1'b0;
        end else begin
            if (bclk_en)
                pos_q <= cur_pos;
            if (!go)
                active_q <= 1'b0;
            else if (frame_start)
                active_q <= 1'b1;
        end
    end

    AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (pos_q == '0));                                   // R1
    AST_ACTIVE_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
        active_q |-> $past(go));                                          // R7
endmodule

// File: rtl/audio_ser_tx_hold.sv
module audio_ser_tx_hold
    import audio_ser_tx_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          run,
    input  logic          fifo_empty,
    input  logic [WW-1:0] fifo_data,
    output logic          pop,
    output logic [WW-1:0] cur_word,
    output logic          underrun
);
    logic [WW-1:0] held_q;
    logic [WW-1:0] fresh;

    assign fresh    = fifo_empty ? '0 : fifo_data;
    assign pop      = take && !fifo_empty;
    assign cur_word = take ? fresh : held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            underrun <= 1'b0;
        end else begin
            if (take)
                held_q <= fresh;
            if (!run)
                underrun <= 1'b0;
            else if (take && fifo_empty)
                underrun <= 1'b1;
        end
    end

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        pop |-> !fifo_empty);                                             // R8
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (take && fifo_empty && run) |=> underrun);                        // R9
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (run && underrun) |=> (underrun || !run));                        // R9
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import audio_ser_tx_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int PW = POS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bclk_en,
    input  logic          frame_en,
    input  logic          run,
    input  logic          pcm_frame,
    input  logic [1:0]    align_mode,
    input  logic [1:0]    pcm_delay,
    input  logic [3:0]    width_code,
    input  logic [1:0]    chan_code,
    input  logic [WW-1:0] fifo_data,
    input  logic          fifo_empty,
    output logic          fifo_pop,
    output logic          sdo,
    output logic          underrun
);
    logic          go;
    logic [PW-1:0] cur_pos;
    logic          frame_start;
    logic          active_now;
    logic [WW-1:0] cur_word;
    frame_cfg_t    cfg;

    assign go  = run && (width_code == WIDTH_CODE_16) && (chan_code == CHAN_CODE_2);
    assign cfg = '{pcm: pcm_frame, align: align_e'(align_mode), delay: pcm_delay};

    audio_ser_tx_bitpos #(.PW(PW)) u_pos (
        .clk         (clk),
        .rst         (rst),
        .bclk_en     (bclk_en),
        .frame_en    (frame_en),
        .go          (go),
        .cur_pos     (cur_pos),
        .frame_start (frame_start),
        .active_now  (active_now)
    );

    audio_ser_tx_hold #(.WW(WW)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .take       (frame_start && active_now),
        .run        (run),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .pop        (fifo_pop),
        .cur_word   (cur_word),
        .underrun   (underrun)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sdo <= 1'b0;
        else if (!go)
            sdo <= 1'b0;
        else if (bclk_en)
            sdo <= active_now ? pick_bit(cur_pos, cur_word, cfg) : 1'b0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !go |=> !sdo);                                                    // R7
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (go && !bclk_en) |=> $stable(sdo));                               // R6
    AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !go |-> !fifo_pop);                                               // R10
endmodule

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0, frame_en = 1'b0, run = 1'b0, pcm_frame = 1'b0;
    logic [1:0]  align_mode = 2'd0, pcm_delay = 2'd0, chan_code = 2'd0;
    logic [3:0]  width_code = 4'hF;
    logic [31:0] fifo_data = 32'h0;
    logic        fifo_empty = 1'b1;
    logic        fifo_pop, sdo, underrun;

    int          total = 0, bad = 0, word_n = 0;
    bit          started = 1'b0, done = 1'b0;
    string       cur_req = "R7";
    logic [31:0] q[$];

    always #5 clk = ~clk;

    audio_ser_tx u_dut (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .frame_en(frame_en), .run(run),
        .pcm_frame(pcm_frame), .align_mode(align_mode), .pcm_delay(pcm_delay),
        .width_code(width_code), .chan_code(chan_code), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .sdo(sdo), .underrun(underrun)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Expected 64-bit frame, index = frame position.
    function automatic logic [63:0] build(logic [31:0] w, bit pcm, logic [1:0] al, logic [1:0] dl);
        logic [63:0] f = '0;
        if (pcm) begin
            for (int j = 0; j < 32; j++)
                f[int'(dl) + j] = (j < 16) ? w[15 - j] : w[47 - j];
        end else begin
            for (int s = 0; s < 2; s++) begin
                int off = (al == 2'd1) ? 0 : (al == 2'd2) ? 16 : 1;
                for (int j = 0; j < 16; j++)
                    f[s * 32 + off + j] = w[s * 16 + 15 - j];
            end
        end
        return f;
    endfunction

    // Enable generator: tick every other cycle, frame every 64 ticks.
    int div = 0, tcnt = 0;
    always @(posedge clk) begin
        #1;
        div = (div + 1) % 2;
        bclk_en = (div == 0);
        if (bclk_en) begin
            frame_en = (tcnt == 0);
            tcnt = (tcnt + 1) % 64;
        end else begin
            frame_en = 1'b0;
        end
    end

    // Reference model and FIFO environment.
    int          mpos = 0;
    bit          mact = 0, exp_sdo = 0, exp_und = 0, mtick = 0;
    logic [63:0] mframe = '0;
    always @(posedge clk) begin : model
        bit go, t0, actn;
        if (rst) begin
            mpos = 0; mact = 0; exp_sdo = 0; exp_und = 0; mframe = '0; mtick = 0;
        end else begin
            go    = run && width_code == 4'hF && chan_code == 2'd0;
            t0    = bclk_en && frame_en;
            mtick = bclk_en;
            if (bclk_en) mpos = frame_en ? 0 : (mpos + 1) % 64;
            actn = go && (mact || t0);
            if (!run) exp_und = 0;
            if (t0 && actn) begin
                if (q.size() == 0) begin
                    exp_und = 1; mframe = '0;
                end else begin
                    mframe = build(q[0], pcm_frame, align_mode, pcm_delay);
                end
            end
            if (!go) exp_sdo = 0;
            else if (bclk_en) exp_sdo = actn ? mframe[mpos] : 1'b0;
            if (!go) mact = 0;
            else if (t0) mact = 1;
        end
        if (fifo_pop && q.size() > 0) void'(q.pop_front());
        fifo_empty <= (q.size() == 0);
        fifo_data  <= (q.size() > 0) ? q[0] : 32'h0;
    end

    always @(negedge clk) begin
        if (started && !done && !rst) begin
            bit exp_pop;
            exp_pop = run && width_code == 4'hF && chan_code == 2'd0 &&
                      bclk_en && frame_en && !fifo_empty;
            chk(mtick ? cur_req : "R6", {31'b0, sdo}, {31'b0, exp_sdo});
            chk("R8", {31'b0, fifo_pop}, {31'b0, exp_pop});
            chk("R9", {31'b0, underrun}, {31'b0, exp_und});
        end
    end

    task automatic phase(string tag, bit pcm, logic [1:0] al, logic [1:0] dl,
                         logic [3:0] wc, logic [1:0] cc, int nwords);
        @(posedge clk); #2;
        run = 1'b0;
        repeat (7) @(posedge clk);
        #2;
        pcm_frame = pcm; align_mode = al; pcm_delay = dl; width_code = wc; chan_code = cc;
        q.delete();
        for (int i = 0; i < nwords; i++) begin
            word_n++;
            q.push_back(32'hA5C3_1E0F ^ (word_n * 32'h9E37_79B1));
        end
        fifo_empty = (q.size() == 0);
        fifo_data  = (q.size() > 0) ? q[0] : 32'h0;
        cur_req = tag;
        run = 1'b1;
        repeat (520 + 13 * word_n % 37) @(posedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R7", {29'b0, sdo, fifo_pop, underrun}, 32'h0);
        started = 1'b1;
        phase("R1", 1'b0, 2'd0, 2'd0, 4'hF, 2'd0, 5);
        phase("R2", 1'b0, 2'd0, 2'd0, 4'hF, 2'd0, 5);
        phase("R3", 1'b0, 2'd1, 2'd0, 4'hF, 2'd0, 5);
        phase("R4", 1'b0, 2'd2, 2'd0, 4'hF, 2'd0, 5);
        phase("R4", 1'b0, 2'd3, 2'd0, 4'hF, 2'd0, 5);
        phase("R5", 1'b1, 2'd0, 2'd0, 4'hF, 2'd0, 5);
        phase("R5", 1'b1, 2'd0, 2'd1, 4'hF, 2'd0, 5);
        phase("R5", 1'b1, 2'd2, 2'd2, 4'hF, 2'd0, 5);
        phase("R5", 1'b1, 2'd1, 2'd3, 4'hF, 2'd0, 5);
        phase("R9", 1'b0, 2'd0, 2'd0, 4'hF, 2'd0, 1);
        phase("R10", 1'b0, 2'd0, 2'd0, 4'hE, 2'd0, 3);
        phase("R10", 1'b0, 2'd1, 2'd0, 4'hF, 2'd1, 3);
        phase("R7", 1'b0, 2'd1, 2'd0, 4'hF, 2'd0, 2);
        @(posedge clk); #2 run = 1'b0;
        repeat (20) @(posedge clk);
        finish_run();
    end

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end
endmodule